// File: doc/BRIEF.md
# Shared Bus Arbiter with Preference, Lockout and Timeout

This block decides which of five masters owns a shared system bus. The masters are numbered by index: 0 is the CPU, 1 the expansion-bus bridge, 2 the core I/O bridge, 3 and 4 the two slot masters. A 32-bit control register gives each non-CPU master a lockout bit and each master a preference bit. It also holds a field giving the number of bus clocks a granted transfer may take before it is declared failed.

Arbitration happens only while the bus is idle. The winner's grant is registered and held for as long as that master keeps its request up. A single preferred master is promised every second arbitration slot. The remaining slots rotate in index order among masters that are requesting and not locked out. While the owner reports its transfer as busy, a counter loaded from the timeout field runs down. When it expires, the grant is withdrawn and a one-cycle bus-error pulse is raised.

Top module: `bus_arb`

## Requirements
- R1: After reset the control register reads 0xFFF80055: the lockout bits 0, 2, 4 and 6 are set, every preference bit is clear, and the timeout field (bits 31:19) is all ones. No grant and no timeout pulse is active.
- R2: The register bits are assigned as follows. Bits 0/1 are the lockout/preference bits of master 1, bits 2/3 those of master 2, bits 4/5 those of master 3 and bits 6/7 those of master 4. Bit 9 is the preference bit of master 0, and bits 31:19 form the timeout count. A write stores only these bits; bit 8 and bits 18:10 always read 0.
- R3: A master whose lockout bit is set is never granted the bus. Master 0 has no lockout bit, so it can be granted right after reset.
- R4: With no preference active, grants rotate in index order 0,1,2,3,4. The search starts at the master after the last winner of a rotating slot, and the first search after reset starts at master 0.
- R5: A single set preference bit reserves every second arbitration for its master, counting from the first arbitration after reset. When that master is requesting and not locked out, it wins the reserved slot. A reserved-slot win does not move the rotation point.
- R6: When more than one preference bit is set, the arbiter behaves as if none were set. A configuration-error flag rises one cycle after the register holds such a value and stays high until reset.
- R7: When a grant is issued, the counter is loaded with the timeout field N. With the busy input held high, the grant lasts N+1 cycles. The grant is then removed and the timeout output is high for exactly the one cycle after removal.
- R8: A grant is held while its master keeps requesting, and the counter does not advance while busy is low. The grant is dropped on the edge after the request falls. The next arbitration follows one idle cycle later.
- R9: At most one grant bit is high at a time. A new grant only goes to a master that was requesting in the arbitration cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_q | output | 32 | Control register contents |
| req | input | 5 | Bus requests, one per master by index |
| xfer_busy | input | 1 | Granted transfer still outstanding |
| gnt | output | 5 | One-hot bus grant |
| bus_tmo | output | 1 | One-cycle bus-error timeout pulse |
| cfg_err | output | 1 | Sticky flag: more than one preference bit set |

## Verification
The assertions check on every cycle that the grant is one-hot. They also check that each new grant went to a master that was requesting and not locked out, that a held grant stays put until its request falls or the counter expires, that the counter never rises except on load, that the timeout pulse lasts one cycle with the bus released, and that the configuration-error flag never clears. Only the bench's scenarios can show the outcomes that depend on history: the exact rotation order, the alternation of reserved slots with and without the CPU preferred, the fallback to plain rotation under conflicting preferences, the N+1 cycle timeout length, and the reset and write-mask contents of the register.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   // register bit of the lockout flag for a non-CPU master (index >= 1)
   function automatic int deny_pos(input int idx);
      return 2 * (idx - 1);
   endfunction

   // register bit of the preference flag; the CPU (index 0) has its own bit
   function automatic int pref_pos(input int idx, input int cpu_bit);
      return (idx == 0) ? cpu_bit : 2 * (idx - 1) + 1;
   endfunction
endpackage

// File: rtl/bus_arb_cfg.sv
module bus_arb_cfg
   import bus_arb_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int NREQ         = 5,
   parameter int CPU_PREF_BIT = 9,
   parameter int TMO_LSB      = 19,
   parameter int TMO_W        = 13,
   parameter logic [TMO_W-1:0] TMO_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q,
   output logic [NREQ-1:0]   deny_vec,
   output logic [NREQ-1:0]   pref_vec,
   output logic [TMO_W-1:0]  tmo_lim,
   output logic              cfg_err
);
   function automatic logic [DATA_W-1:0] f_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < NREQ; i++) begin
         m[pref_pos(i, CPU_PREF_BIT)] = 1'b1;
         if (i > 0) m[deny_pos(i)] = 1'b1;
      end
      for (int b = TMO_LSB; b < TMO_LSB + TMO_W; b++) m[b] = 1'b1;
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] f_rst();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 1; i < NREQ; i++) m[deny_pos(i)] = 1'b1;
      m[TMO_LSB +: TMO_W] = TMO_RST;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] WMASK   = f_mask();
   localparam logic [DATA_W-1:0] RST_VAL = f_rst();

   logic [DATA_W-1:0] ctl_q;
   logic [NREQ-1:0]   pref_raw;
   logic              multi_pref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= RST_VAL;
      else if (we) ctl_q <= wdata & WMASK;
   end

   for (genvar i = 0; i < NREQ; i++) begin : g_field
      localparam int PB = pref_pos(i, CPU_PREF_BIT);
      assign pref_raw[i] = ctl_q[PB];
      if (i == 0) begin : g_cpu
         assign deny_vec[i] = 1'b0;
      end else begin : g_dev
         localparam int DB = deny_pos(i);
         assign deny_vec[i] = ctl_q[DB];
      end
   end

   assign multi_pref = ($countones(pref_raw) > 1);
   assign pref_vec   = multi_pref ? '0 : pref_raw;
   assign tmo_lim    = ctl_q[TMO_LSB +: TMO_W];
   assign q          = ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_err <= 1'b0;
      else if (multi_pref) cfg_err <= 1'b1;
   end

   assert_cfg_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   assert_pref_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pref_vec));
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick #(
   parameter int NREQ  = 5,
   parameter int IDX_W = $clog2(NREQ)
) (
   input  logic [NREQ-1:0]  req_ok,
   input  logic [NREQ-1:0]  pref_vec,
   input  logic             pref_slot,
   input  logic [IDX_W-1:0] ptr,
   output logic [NREQ-1:0]  win,
   output logic             win_pref
);
   logic found;

   always_comb begin
      win      = '0;
      win_pref = 1'b0;
      found    = 1'b0;
      if (pref_slot && |(pref_vec & req_ok)) begin
         win      = pref_vec & req_ok;
         win_pref = 1'b1;
      end else begin
         for (int k = 1; k <= NREQ; k++) begin
            if (!found && req_ok[(int'(ptr) + k) % NREQ]) begin
               win[(int'(ptr) + k) % NREQ] = 1'b1;
               found = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bus_arb_tmo.sv
module bus_arb_tmo #(
   parameter int TMO_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMO_W-1:0] lim,
   input  logic             run,
   output logic             expire
);
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= lim;
      else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire = run && (cnt_q == '0);

   assert_cnt_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> (cnt_q <= $past(cnt_q)));
   assert_cnt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/bus_arb.sv
module bus_arb
   import bus_arb_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int NREQ         = 5,
   parameter int CPU_PREF_BIT = 9,
   parameter int TMO_LSB      = 19,
   parameter int TMO_W        = DATA_W - TMO_LSB,
   parameter logic [TMO_W-1:0] TMO_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_q,
   input  logic [NREQ-1:0]   req,
   input  logic              xfer_busy,
   output logic [NREQ-1:0]   gnt,
   output logic              bus_tmo,
   output logic              cfg_err
);
   localparam int IDX_W = $clog2(NREQ);

   if (TMO_LSB + TMO_W > DATA_W) begin : g_chk_tmo
      $error("timeout field exceeds register width");
   end
   if (2 * (NREQ - 1) > CPU_PREF_BIT || CPU_PREF_BIT >= TMO_LSB) begin : g_chk_cpu
      $error("CPU preference bit collides with another field");
   end
   if (NREQ < 2) begin : g_chk_n
      $error("arbiter needs at least two masters");
   end

   logic [NREQ-1:0]  deny_vec, pref_vec, req_ok, win;
   logic [TMO_W-1:0] tmo_lim;
   logic             win_pref, idle, issue, expire, run;
   logic [NREQ-1:0]  gnt_q;
   logic [IDX_W-1:0] ptr_q, win_idx;
   logic             slot_q, tmo_q;

   bus_arb_cfg #(
      .DATA_W(DATA_W), .NREQ(NREQ), .CPU_PREF_BIT(CPU_PREF_BIT),
      .TMO_LSB(TMO_LSB), .TMO_W(TMO_W), .TMO_RST(TMO_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q),
      .deny_vec(deny_vec), .pref_vec(pref_vec), .tmo_lim(tmo_lim), .cfg_err(cfg_err)
   );

   assign req_ok = req & ~deny_vec;
   assign idle   = (gnt_q == '0);
   assign issue  = idle && (win != '0);
   assign run    = !idle && xfer_busy;

   bus_arb_pick #(.NREQ(NREQ), .IDX_W(IDX_W)) u_pick (
      .req_ok(req_ok), .pref_vec(pref_vec), .pref_slot(slot_q), .ptr(ptr_q),
      .win(win), .win_pref(win_pref)
   );

   bus_arb_tmo #(.TMO_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n), .load(issue), .lim(tmo_lim), .run(run), .expire(expire)
   );

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (win[i]) win_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         ptr_q  <= IDX_W'(NREQ - 1);
         slot_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         tmo_q <= 1'b0;
         if (idle) begin
            if (issue) begin
               gnt_q  <= win;
               slot_q <= ~slot_q;
               if (!win_pref) ptr_q <= win_idx;
            end
         end else if ((gnt_q & req) == '0) begin
            gnt_q <= '0;
         end else if (expire) begin
            gnt_q <= '0;
            tmo_q <= 1'b1;
         end
      end
   end

   assign gnt     = gnt_q;
   assign bus_tmo = tmo_q;

   assert_gnt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));
   assert_gnt_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_q != '0) && ($past(gnt_q) == '0)) |-> ((gnt_q & $past(req)) == gnt_q));
   assert_gnt_not_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_q != '0) && ($past(gnt_q) == '0)) |-> ((gnt_q & $past(deny_vec)) == '0));
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt_q != '0) && ((gnt_q & req) != '0) && !expire) |=> (gnt_q == $past(gnt_q)));
   assert_tmo_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |=> !tmo_q);
   assert_tmo_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> (gnt_q == '0));
endmodule

// File: tb/bus_arb_tb.sv
`timescale 1ns/1ps
module bus_arb_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_q;
   logic [4:0]  req = '0;
   logic        xfer_busy = 1'b0;
   logic [4:0]  gnt;
   logic        bus_tmo;
   logic        cfg_err;

   int n_run = 0;
   int n_fail = 0;
   int seq[8];
   bit done_flag = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   bus_arb u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .req(req), .xfer_busy(xfer_busy), .gnt(gnt), .bus_tmo(bus_tmo), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req = '0; xfer_busy = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic int idx_of(input logic [4:0] g);
      for (int i = 0; i < 5; i++) if (g[i]) return i;
      return -1;
   endfunction

   // masters in mask keep requesting; each owner drops its request once granted
   task automatic collect(input logic [4:0] mask, input int n);
      req = mask;
      for (int g = 0; g < n; g++) begin
         do @(negedge clk); while (gnt == '0);
         seq[g] = idx_of(gnt);
         req = mask & ~gnt;
         @(negedge clk);
         req = mask;
      end
      req = '0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(cfg_q == 32'hFFF8_0055, "R1 reset register", cfg_q, 32'hFFF8_0055);
      chk(gnt == '0, "R1 reset grant", 32'(gnt), 0);
      chk(bus_tmo == 1'b0 && cfg_err == 1'b0, "R1 reset flags", {bus_tmo, cfg_err}, 0);
   endtask

   task automatic t_wmask();
      do_reset();
      wr_cfg(32'hFFFF_FFFF);
      chk(cfg_q == 32'hFFF8_02FF, "R2 write mask", cfg_q, 32'hFFF8_02FF);
      wr_cfg(32'h0007_FD00);
      chk(cfg_q == 32'h0000_0000, "R2 undefined bits read zero", cfg_q, 0);
   endtask

   task automatic t_deny();
      do_reset();
      req = 5'b11110;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gnt != '0) chk(1'b0, "R3 locked-out master granted", 32'(gnt), 0);
      end
      chk(gnt == '0, "R3 all locked out", 32'(gnt), 0);
      req = 5'b11111;
      @(negedge clk);
      chk(gnt == 5'b00001, "R3 CPU grantable at reset", 32'(gnt), 1);
      req = '0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_rr();
      int e[4] = '{1, 2, 1, 2};
      do_reset();
      wr_cfg(32'h0000_0050);
      collect(5'b00110, 4);
      for (int i = 0; i < 4; i++)
         chk(seq[i] == e[i], "R4 rotation order", seq[i], e[i]);
   endtask

   task automatic t_pref_dev();
      int e[8] = '{1, 1, 2, 1, 1, 1, 2, 1};
      do_reset();
      wr_cfg(32'h0000_0052);
      collect(5'b00110, 8);
      for (int i = 0; i < 8; i++)
         chk(seq[i] == e[i], "R5 preferred master 1 sequence", seq[i], e[i]);
   endtask

   task automatic t_pref_cpu();
      int e[8] = '{0, 0, 1, 0, 2, 0, 3, 0};
      do_reset();
      wr_cfg(32'h0000_0200);
      collect(5'b11111, 8);
      for (int i = 0; i < 8; i++)
         chk(seq[i] == e[i], "R5 preferred CPU sequence", seq[i], e[i]);
   endtask

   task automatic t_multi();
      int e[6] = '{1, 2, 3, 1, 2, 3};
      do_reset();
      wr_cfg(32'h0000_0062);
      @(negedge clk);
      chk(cfg_err == 1'b1, "R6 config error raised", 32'(cfg_err), 1);
      collect(5'b01110, 6);
      for (int i = 0; i < 6; i++)
         chk(seq[i] == e[i], "R6 conflicting preference ignored", seq[i], e[i]);
      wr_cfg(32'h0000_0040);
      @(negedge clk);
      chk(cfg_err == 1'b1, "R6 config error sticky", 32'(cfg_err), 1);
   endtask

   task automatic t_timeout();
      int held = 0;
      do_reset();
      wr_cfg((32'd3 << 19) | 32'h54);
      xfer_busy = 1'b1;
      req = 5'b00010;
      do @(negedge clk); while (gnt == '0);
      while (gnt == 5'b00010 && held < 50) begin
         held++;
         if (bus_tmo) chk(1'b0, "R7 early timeout", 1, 0);
         @(negedge clk);
      end
      chk(held == 4, "R7 grant length N+1", held, 4);
      chk(gnt == '0, "R7 grant removed", 32'(gnt), 0);
      chk(bus_tmo == 1'b1, "R7 timeout pulse", 32'(bus_tmo), 1);
      req = '0; xfer_busy = 1'b0;
      @(negedge clk);
      chk(bus_tmo == 1'b0, "R7 pulse one cycle", 32'(bus_tmo), 0);
   endtask

   task automatic t_hold();
      do_reset();
      wr_cfg((32'd3 << 19) | 32'h54);
      xfer_busy = 1'b0;
      req = 5'b00011;
      @(negedge clk);
      chk(gnt == 5'b00001, "R9 grant goes to CPU first", 32'(gnt), 1);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (gnt != 5'b00001 || bus_tmo) chk(1'b0, "R8 grant held idle busy", 32'(gnt), 1);
      end
      chk(gnt == 5'b00001 && !bus_tmo, "R8 held without timeout", 32'(gnt), 1);
      req = 5'b00010;
      @(negedge clk);
      chk(gnt == '0, "R8 release after drop", 32'(gnt), 0);
      @(negedge clk);
      chk(gnt == 5'b00010, "R8 next grant after idle cycle", 32'(gnt), 2);
      req = '0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      t_reset();
      t_wmask();
      t_deny();
      t_rr();
      t_pref_dev();
      t_pref_cpu();
      t_multi();
      t_timeout();
      t_hold();
      finish_up();
   end
endmodule